// File: doc/BRIEF.md
# Bank Pin-Change Interrupt Detector

This block watches the already-synchronized levels of one bank of general-purpose pins and turns selected pin activity into one interrupt line for the bank. The bank is split into ports of eight pins each. Each port has four words in the block's register space: a status word (read only), an enable word, a trigger-type word and a write-one-to-clear word. Enable and trigger type also have masked aliases, so software can change single pins without a read-modify-write.

Each pin is given a trigger condition: a rising edge, a falling edge, either edge, a high level or a low level. The condition is coded as three bits spread over three byte lanes of the trigger-type word. An edge-triggered pin latches its status bit and holds it until software clears it. A level-triggered pin's status bit tracks the active level. A pin counts as pending when its status bit and its enable bit are both set. The registered interrupt output goes high whenever any pin in the bank is pending.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is held, the enable and trigger-type words of every port read 0, status reads 0 and `irq` is low.
- R2: For port p, status is at 0x40+4p, enable at 0x50+4p, trigger type at 0x60+4p and clear at 0x70+4p. Enable and type read back what was written. In the type word, for pin b, bit b is polarity, bit b+8 is edge mode and bit b+16 is either-edge.
- R3: A write to 0xD0+4p updates only the enable bits whose mask bit in wdata[15:8] is 1, taking their values from wdata[7:0]. A write to 0xE0+4p updates all three type bits of only those pins whose mask bit in wdata[31:24] is 1, taking their values from wdata[23:0] laid out as in R2. Pins whose mask bit is 0 keep their settings.
- R4: Type code 0x000101<<b detects a rising edge, 0x000100<<b a falling edge and 0x010100<<b either edge. The matching edge sets status bit b on the clock edge at which the new level is sampled.
- R5: An edge-mode status bit stays set until it is cleared. An edge that does not match the pin's type leaves status unchanged.
- R6: Writing 1 to bit b of the clear word clears status bit b of an edge-mode pin. Writing 0 has no effect. A later matching edge sets the bit again.
- R7: If a matching edge and a clear for the same pin arrive in the same cycle, the status bit stays set.
- R8: Type code 0x000001<<b (level high) or 0 (level low) makes status bit b equal the pin's active condition one cycle later. A clear written while the level is still active leaves the bit set.
- R9: A pin whose enable bit is 0 never raises `irq`, even when its status bit is set.
- R10: `irq` is registered. It rises one cycle after a status bit of an enabled pin becomes set, and it falls one cycle after the last pending pin goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NPORT*PW (32) | Synchronized pin levels, port p occupying bits [8p+7:8p] |
| bus_addr | input | AW (12) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe; the write takes effect on the next clock edge |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| irq | output | 1 | Bank interrupt, high while any enabled status bit is set (one-cycle lag) |

## Verification
The bench aims at the cases where a small logic slip still looks plausible. These include an edge of the wrong direction on an edge-mode pin, which a design with swapped polarity would latch. They include a clear that lands in the same cycle as a new edge, which a design that gives priority to clear would lose. The bench also writes a zero clear mask, which a design treating the word as plain data would turn into a wipe. Masked writes are checked with value bits set outside the mask, which a design that ignores the mask would apply. The bench also times the one-cycle rise and fall of `irq` exactly, and checks that a level-triggered pin cannot be cleared while its level is still active.

// File: rtl/gid_pkg.sv
package gid_pkg;

  // Word offsets inside one bank (port index adds 4*p)
  localparam int OFS_STA = 'h40;
  localparam int OFS_EN  = 'h50;
  localparam int OFS_TYP = 'h60;
  localparam int OFS_CLR = 'h70;

  // Per-pin trigger setting, one bit taken from each type byte lane
  typedef struct packed {
    logic both;  // either-edge select
    logic edm;   // 1: edge mode, 0: level mode
    logic pol;   // 1: rising / high, 0: falling / low
  } trig_t;

  // True when the sampled transition matches an edge-mode setting
  function automatic logic trig_hit(trig_t t, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    if (!t.edm) return 1'b0;
    if (t.both) return rise | fall;
    return t.pol ? rise : fall;
  endfunction

  // True when a level-mode pin sits at its active level
  function automatic logic trig_active(trig_t t, logic cur);
    return !t.edm && (cur == t.pol);
  endfunction

endpackage

// File: rtl/gid_regs.sv
module gid_regs #(
  parameter int NPORT     = 4,
  parameter int PW        = 8,
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter int UPPER_OFS = 'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_wr,
  input  logic [DW-1:0]          bus_wdata,
  input  logic [NPORT*PW-1:0]    sta_i,
  output logic [DW-1:0]          bus_rdata,
  output logic [NPORT*PW-1:0]    en_o,
  output logic [NPORT*PW-1:0]    pol_o,
  output logic [NPORT*PW-1:0]    edm_o,
  output logic [NPORT*PW-1:0]    both_o,
  output logic [NPORT*PW-1:0]    clr_o
);
  import gid_pkg::*;

  localparam int PSEL_W = $clog2(NPORT);
  localparam logic [AW-1:0] A_STA = AW'(OFS_STA);
  localparam logic [AW-1:0] A_EN  = AW'(OFS_EN);
  localparam logic [AW-1:0] A_TYP = AW'(OFS_TYP);
  localparam logic [AW-1:0] A_CLR = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_MEN = AW'(UPPER_OFS + OFS_EN);
  localparam logic [AW-1:0] A_MTY = AW'(UPPER_OFS + OFS_TYP);

  // Keep bits outside the mask, take new values inside it
  function automatic logic [PW-1:0] merge(logic [PW-1:0] old_v,
                                          logic [PW-1:0] new_v,
                                          logic [PW-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  logic [AW-1:0]     grp;
  logic [PSEL_W-1:0] psel;
  assign grp  = {bus_addr[AW-1:4], 4'h0};
  assign psel = bus_addr[PSEL_W+1:2];

  logic wr_en, wr_men, wr_typ, wr_mty, wr_clr;
  assign wr_en  = bus_wr && (grp == A_EN);
  assign wr_men = bus_wr && (grp == A_MEN);
  assign wr_typ = bus_wr && (grp == A_TYP);
  assign wr_mty = bus_wr && (grp == A_MTY);
  assign wr_clr = bus_wr && (grp == A_CLR);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int LO = p * PW;
    logic          sel;
    logic [PW-1:0] en_r, pol_r, edm_r, both_r;
    logic [PW-1:0] tmsk;
    assign sel  = (psel == PSEL_W'(p));
    assign tmsk = bus_wdata[4*PW-1:3*PW];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r   <= '0;
        pol_r  <= '0;
        edm_r  <= '0;
        both_r <= '0;
      end else if (sel) begin
        if (wr_en)
          en_r <= bus_wdata[PW-1:0];
        else if (wr_men)
          en_r <= merge(en_r, bus_wdata[PW-1:0], bus_wdata[2*PW-1:PW]);
        if (wr_typ) begin
          pol_r  <= bus_wdata[PW-1:0];
          edm_r  <= bus_wdata[2*PW-1:PW];
          both_r <= bus_wdata[3*PW-1:2*PW];
        end else if (wr_mty) begin
          pol_r  <= merge(pol_r,  bus_wdata[PW-1:0],      tmsk);
          edm_r  <= merge(edm_r,  bus_wdata[2*PW-1:PW],   tmsk);
          both_r <= merge(both_r, bus_wdata[3*PW-1:2*PW], tmsk);
        end
      end
    end

    assign en_o[LO +: PW]   = en_r;
    assign pol_o[LO +: PW]  = pol_r;
    assign edm_o[LO +: PW]  = edm_r;
    assign both_o[LO +: PW] = both_r;
    assign clr_o[LO +: PW]  = (sel && wr_clr) ? bus_wdata[PW-1:0] : '0;
  end

  // Read mux, combinational on the address
  always_comb begin
    bus_rdata = '0;
    if (grp == A_STA)
      bus_rdata = DW'(sta_i[int'(psel)*PW +: PW]);
    else if (grp == A_EN)
      bus_rdata = DW'(en_o[int'(psel)*PW +: PW]);
    else if (grp == A_TYP)
      bus_rdata = DW'({both_o[int'(psel)*PW +: PW],
                       edm_o[int'(psel)*PW +: PW],
                       pol_o[int'(psel)*PW +: PW]});
  end

endmodule

// File: rtl/gid_pin_detect.sv
module gid_pin_detect (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  gid_pkg::trig_t cfg,
  input  logic          clr,
  output logic          hit_o,
  output logic          sta_o
);
  import gid_pkg::*;

  logic prev_q;
  logic sta_q;
  logic act;
  logic sta_d;

  assign hit_o = trig_hit(cfg, prev_q, pin);
  assign act   = trig_active(cfg, pin);

  // Edge mode: sticky, edge beats clear. Level mode: track active level.
  always_comb begin
    if (cfg.edm) sta_d = hit_o | (sta_q & ~clr);
    else         sta_d = act;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sta_q  <= 1'b0;
    end else begin
      prev_q <= pin;
      sta_q  <= sta_d;
    end
  end

  assign sta_o = sta_q;

  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> sta_q);

  a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edm && sta_q && !clr) |=> sta_q);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edm && sta_q && clr && !hit_o) |=> !sta_q);

endmodule

// File: rtl/gid_irq_out.sv
module gid_irq_out #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] sta_i,
  input  logic [NPIN-1:0] en_i,
  output logic            irq_o
);
  logic [NPIN-1:0] pend;
  logic            any_pend;

  assign pend     = sta_i & en_i;
  assign any_pend = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_pend;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPORT     = 4,
  parameter int PW        = 8,
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter int UPPER_OFS = 'h80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT*PW-1:0] pin_lvl,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq
);
  import gid_pkg::*;

  localparam int NPIN = NPORT * PW;

  logic [NPIN-1:0] en, pol, edm, both, clr, sta, hit;

  gid_regs #(
    .NPORT(NPORT), .PW(PW), .AW(AW), .DW(DW), .UPPER_OFS(UPPER_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .sta_i    (sta),
    .bus_rdata(bus_rdata),
    .en_o     (en),
    .pol_o    (pol),
    .edm_o    (edm),
    .both_o   (both),
    .clr_o    (clr)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    trig_t cfg;
    assign cfg = '{both: both[i], edm: edm[i], pol: pol[i]};
    gid_pin_detect u_pin (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_lvl[i]),
      .cfg  (cfg),
      .clr  (clr[i]),
      .hit_o(hit[i]),
      .sta_o(sta[i])
    );
  end

  gid_irq_out #(.NPIN(NPIN)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .sta_i(sta),
    .en_i (en),
    .irq_o(irq)
  );

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & clr) != '0) |=> ((sta & $past(hit & clr)) == $past(hit & clr)));

  a_r9_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(sta & en) != '0));

  a_r10_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    ((sta & en) == '0) |=> !irq);

endmodule

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int NPIN = 32;
  localparam int STA = 'h40, EN = 'h50, TYP = 'h60, CLR = 'h70;
  localparam int MEN = 'hD0, MTY = 'hE0;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIN-1:0] pins = '0;
  logic [AW-1:0]   addr = '0;
  logic            wr = 1'b0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic            irq;

  gpio_irq_detect u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .bus_addr(addr),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always #10ns clk = ~clk;

  typedef struct {
    bit            is_irq;
    logic [DW-1:0] exp;
    string         req;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic logic [AW-1:0] ra(int base, int port);
    return AW'(base + 4 * port);
  endfunction

  task automatic chk_rd(int base, int port, logic [DW-1:0] e, string r);
    @(negedge clk);
    wr = 1'b0;
    addr = ra(base, port);
    q.push_back('{1'b0, e, r});
  endtask

  task automatic now_irq(logic e, string r);
    q.push_back('{1'b1, DW'(e), r});
  endtask

  task automatic chk_irq(logic e, string r);
    @(negedge clk);
    wr = 1'b0;
    now_irq(e, r);
  endtask

  task automatic wr_reg_pins(int base, int port, logic [DW-1:0] d,
                             logic [NPIN-1:0] pv);
    @(negedge clk);
    addr  = ra(base, port);
    wdata = d;
    wr    = 1'b1;
    pins  = pv;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic wr_reg(int base, int port, logic [DW-1:0] d);
    wr_reg_pins(base, port, d, pins);
  endtask

  task automatic set_pins(logic [NPIN-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: drains expected items shortly after each falling edge
  always @(negedge clk) begin
    #3ns;
    while (q.size() > 0) begin
      item_t         it;
      logic [DW-1:0] act;
      it  = q.pop_front();
      act = it.is_irq ? DW'(irq) : rdata;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    // R1: state held in reset
    chk_rd(EN, 0, 32'h0, "R1 enable");
    chk_rd(TYP, 1, 32'h0, "R1 type");
    chk_rd(STA, 2, 32'h0, "R1 status");
    chk_irq(1'b0, "R1 irq");
    @(negedge clk);
    rst_n = 1'b1;

    // R9: level-low default sets status, enables are off
    chk_rd(STA, 0, 32'hFF, "R9 status set");
    chk_irq(1'b0, "R9 no irq");

    // R2: port 0 pin0 rise, pin1 fall, pin2 either, pin3 high, rest low
    wr_reg(TYP, 0, 32'h040709);
    chk_rd(TYP, 0, 32'h040709, "R2 type readback");
    set_pins(32'h0000_00F2);
    wr_reg(CLR, 0, 32'hFF);
    chk_rd(STA, 0, 32'h00, "R6 clear all");

    // R4 edge kinds
    set_pins(32'h0000_00F3);
    chk_rd(STA, 0, 32'h01, "R4 rising");
    set_pins(32'h0000_00F1);
    chk_rd(STA, 0, 32'h03, "R4 falling");
    set_pins(32'h0000_00F5);
    chk_rd(STA, 0, 32'h07, "R4 either rise");
    wr_reg(CLR, 0, 32'h04);
    chk_rd(STA, 0, 32'h03, "R6 single clear");
    set_pins(32'h0000_00F1);
    chk_rd(STA, 0, 32'h07, "R4 either fall");

    // R5 wrong direction, stickiness
    wr_reg(CLR, 0, 32'h03);
    chk_rd(STA, 0, 32'h04, "R6 partial clear");
    set_pins(32'h0000_00F2);
    chk_rd(STA, 0, 32'h04, "R5 wrong edges");
    repeat (4) @(negedge clk);
    chk_rd(STA, 0, 32'h04, "R5 sticky");

    // R6 zero write, clear, re-arm
    wr_reg(CLR, 0, 32'h00);
    chk_rd(STA, 0, 32'h04, "R6 zero write");
    wr_reg(CLR, 0, 32'h04);
    chk_rd(STA, 0, 32'h00, "R6 cleared");
    set_pins(32'h0000_00F6);
    chk_rd(STA, 0, 32'h04, "R6 new edge");

    // R7 edge and clear together
    wr_reg_pins(CLR, 0, 32'h04, 32'h0000_00F2);
    chk_rd(STA, 0, 32'h04, "R7 edge wins");
    wr_reg(CLR, 0, 32'h04);
    chk_rd(STA, 0, 32'h00, "R7 later clear");

    // R8 level modes
    set_pins(32'h0000_00FA);
    chk_rd(STA, 0, 32'h08, "R8 high active");
    wr_reg(CLR, 0, 32'h08);
    chk_rd(STA, 0, 32'h08, "R8 clear overridden");
    set_pins(32'h0000_00F2);
    chk_rd(STA, 0, 32'h00, "R8 high inactive");
    set_pins(32'h0000_0072);
    chk_rd(STA, 0, 32'h80, "R8 low active");
    set_pins(32'h0000_00F2);
    chk_rd(STA, 0, 32'h00, "R8 low inactive");

    // R10 interrupt timing
    wr_reg(EN, 0, 32'h01);
    chk_rd(EN, 0, 32'h01, "R2 enable readback");
    set_pins(32'h0000_00F3);
    chk_irq(1'b0, "R10 one-cycle lag");
    chk_irq(1'b1, "R10 raised");
    wr_reg(CLR, 0, 32'h01);
    now_irq(1'b1, "R10 still high");
    chk_irq(1'b0, "R10 dropped");

    // R9 disabled pin
    set_pins(32'h0000_00F7);
    chk_rd(STA, 0, 32'h04, "R9 status");
    chk_irq(1'b0, "R9 masked");
    chk_irq(1'b0, "R9 masked later");

    // R3 masked aliases
    wr_reg(MEN, 0, 32'h0000_0602);
    chk_rd(EN, 0, 32'h03, "R3 masked enable set");
    wr_reg(MEN, 0, 32'h0000_0100);
    chk_rd(EN, 0, 32'h02, "R3 masked enable clear");
    wr_reg(MTY, 1, 32'h2000_6060);
    chk_rd(TYP, 1, 32'h0000_2020, "R3 masked type");
    wr_reg(CLR, 1, 32'hFF);
    chk_rd(STA, 1, 32'hDF, "R3 port1 after clear");
    set_pins(32'h0000_20F7);
    chk_rd(STA, 1, 32'hFF, "R3 port1 rising");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule